// File: doc/BRIEF.md
# Two-Wire Slave Port for a Timekeeping Register Bank

This block is the serial-bus front end of a real-time clock. A bus master reaches it over the two-wire I2C bus. The block watches SCL and SDA, finds START, repeated START and STOP events, and checks each address byte against a fixed 7-bit device address. It keeps a volatile word pointer that selects one register of a small bank. Writes set the pointer first, and any further bytes are handed to the time-counting logic through a write strobe. Reads stream bytes out starting at the pointer. The pointer can come from a write earlier in the same transaction (a random read), or it can be the value left over from the last transaction (a current-address read).

The first registers of the bank are a user-visible copy of the live time, and the block refreshes them from a parallel input vector on every clock. While an addressed transaction is open and the pointer sits inside the clock range, the copy stops refreshing. A multi-byte read therefore returns one consistent time. Refreshing starts again on STOP, or as soon as the pointer steps past the clock range. Registers above that range hold only what the master writes into them.

Top module: `rtc_i2c_slave`

## Requirements
- R1: The block acknowledges only an address byte whose upper seven bits are 1101000 (bit 0 is R/W, 0 = write, 1 = read). For any other address it leaves SDA released for the rest of the transaction and raises no write strobe.
- R2: In a write transaction, the first byte after the address acknowledge loads the pointer. Each later byte is acknowledged and produces one write strobe carrying the current pointer and the byte. The pointer then steps by one and wraps at the bank size. A write to a register above the clock range is later returned by a read.
- R3: A read sends the byte at the pointer MSB first. SDA is changed only while SCL is low, and it holds steady through each SCL high phase.
- R4: A read transaction with no pointer write returns the register selected by the pointer as the previous transaction left it.
- R5: During a read, the pointer steps by one only when the master acknowledges on the ninth clock. A NACK leaves it unchanged, so consecutive acknowledged reads return consecutive registers.
- R6: After a master NACK the block releases SDA and drives nothing until the next START or STOP.
- R7: While an addressed transaction is open and the pointer is below the clock-register count (7), the clock copy keeps the value it had when the freeze began, even if the live time changes.
- R8: A STOP ends the freeze, and the clock copy then follows the live time again.
- R9: When the pointer steps to 7 during a read, refreshing resumes without a STOP.
- R10: The freeze also holds through a write transaction followed by a repeated START and a read.
- R11: After reset, SDA is released and the pointer is 0.
- R12: A START that arrives part-way through a byte discards the partial byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| live_time_i | input | NCLK*8 (56) | Live time; register k is bits [8k+7:8k] |
| set_we_o | output | 1 | One-cycle write strobe to the time logic |
| set_addr_o | output | $clog2(NREGS) (3) | Register index of the write |
| set_data_o | output | 8 | Byte being written |

## Verification
The assertions assume that SCL and SDA are slow next to clk, with each level held for several clock cycles. They also assume that SDA moves only while SCL is low, except for the deliberate START and STOP transitions, and that SCL and SDA never change in the same cycle. The bench master holds every bus phase for ten clock cycles and changes its SDA only in the SCL-low quarter. It reads back a wired-AND of its own SDA and the block's pull. Within those limits, the properties check that SDA changes only when SCL is low, that the pointer moves only after a received byte or a master acknowledge, and that the clock copy stays put while frozen.

// File: rtl/rtcif_pkg.sv
package rtcif_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_MACK, ST_WAIT
  } bus_state_t;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC-1:0] scl_sr, sda_sr;
  logic            scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC-2:0], sda_i};
      scl_d  <= scl_sr[SYNC-1];
      sda_d  <= sda_sr[SYNC-1];
    end
  end

  assign scl_lvl  = scl_sr[SYNC-1];
  assign sda_lvl  = sda_sr[SYNC-1];
  assign scl_rise = scl_lvl & ~scl_d;
  assign scl_fall = ~scl_lvl & scl_d;
  assign start_ev = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow #(
  parameter int NREGS = 8,
  parameter int NCLK  = 7,
  parameter int DW    = 8,
  parameter int AW    = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               freeze,
  input  logic [NCLK*DW-1:0] live,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [AW-1:0]      raddr,
  output logic [DW-1:0]      rdata,
  output logic [NCLK*DW-1:0] clk_view
);
  logic [DW-1:0]       bank [NREGS];
  logic [NREGS*DW-1:0] live_pad;

  assign live_pad = (NREGS*DW)'(live);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank <= '{default: '0};
    end else begin
      for (int i = 0; i < NREGS; i++) begin
        if (we && waddr == AW'(i))
          bank[i] <= wdata;
        else if (i < NCLK && !freeze)
          bank[i] <= live_pad[i*DW +: DW];
      end
    end
  end

  assign rdata = (32'(raddr) < NREGS) ? bank[raddr] : '0;

  for (genvar g = 0; g < NCLK; g++) begin : g_view
    assign clk_view[g*DW +: DW] = bank[g];
  end
endmodule

// File: rtl/rtc_i2c_slave.sv
module rtc_i2c_slave
  import rtcif_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int NREGS = 8,
  parameter int NCLK  = 7,
  parameter int SYNC  = 2,
  localparam int DW   = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [NCLK*DW-1:0] live_time_i,
  output logic               set_we_o,
  output logic [AW-1:0]      set_addr_o,
  output logic [DW-1:0]      set_data_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  bus_state_t state;
  logic [3:0]    bitcnt;
  logic [DW-1:0] shreg;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] ptr;
  logic          rw, first_byte, active, mack, freeze;
  logic [NCLK*DW-1:0] clk_view;

  i2c_line_mon #(.SYNC(SYNC)) u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign freeze = active && (32'(ptr) < NCLK);

  rtc_shadow #(.NREGS(NREGS), .NCLK(NCLK), .DW(DW), .AW(AW)) u_bank (
    .clk(clk), .rst(rst), .freeze(freeze), .live(live_time_i),
    .we(set_we_o), .waddr(set_addr_o), .wdata(set_data_o),
    .raddr(ptr), .rdata(rd_data), .clk_view(clk_view)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      rw         <= 1'b0;
      first_byte <= 1'b0;
      ptr        <= '0;
      active     <= 1'b0;
      mack       <= 1'b0;
      sda_pull_o <= 1'b0;
      set_we_o   <= 1'b0;
      set_addr_o <= '0;
      set_data_o <= '0;
    end else begin
      set_we_o <= 1'b0;
      if (stop_ev) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
        active     <= 1'b0;
        bitcnt     <= '0;
      end else if (start_ev) begin
        state      <= ST_ADDR;
        sda_pull_o <= 1'b0;
        bitcnt     <= '0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[DW-2:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_pull_o <= 1'b1;
                rw         <= shreg[0];
                active     <= 1'b1;
                state      <= ST_AACK;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                shreg      <= rd_data;
                sda_pull_o <= ~rd_data[DW-1];
                state      <= ST_TX;
              end else begin
                sda_pull_o <= 1'b0;
                first_byte <= 1'b1;
                state      <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[DW-2:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              sda_pull_o <= 1'b1;
              state      <= ST_RACK;
              if (first_byte) begin
                ptr <= shreg[AW-1:0];
              end else begin
                set_we_o   <= 1'b1;
                set_addr_o <= ptr;
                set_data_o <= shreg;
                ptr        <= ptr + AW'(1);
              end
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              bitcnt     <= '0;
              first_byte <= 1'b0;
              state      <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_pull_o <= 1'b0;
                state      <= ST_MACK;
              end else if (bitcnt != 4'd0) begin
                shreg      <= {shreg[DW-2:0], 1'b0};
                sda_pull_o <= ~shreg[DW-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
              if (!sda_lvl) ptr <= ptr + AW'(1);
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (mack) begin
                shreg      <= rd_data;
                sda_pull_o <= ~rd_data[DW-1];
                state      <= ST_TX;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_i2c_slave_chk.sv
module rtc_i2c_slave_chk
  import rtcif_pkg::*;
#(
  parameter int AW   = 3,
  parameter int NCLK = 7,
  parameter int DW   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_lvl,
  input logic               start_ev,
  input logic               stop_ev,
  input logic               sda_pull_o,
  input bus_state_t         state,
  input logic [AW-1:0]      ptr,
  input logic               freeze,
  input logic               set_we_o,
  input logic [NCLK*DW-1:0] clk_view
);
  // R11: reset leaves the line released and the pointer at zero
  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sda_pull_o && ptr == '0));

  // R1 / R6: no pull while idle or ignoring the bus
  a_r1_idle_no_pull: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_WAIT) |-> !sda_pull_o);

  // R3: the pull changes only with SCL low, apart from START/STOP release
  a_r3_drive_while_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> (!scl_lvl || $past(start_ev || stop_ev)));

  // R5: the pointer moves only after a received byte or a master acknowledge
  a_r5_ptr_source: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr) |-> ($past(state) == ST_RX || $past(state) == ST_MACK));

  // R7: the frozen copy changes only through a write strobe
  a_r7_frozen_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(freeze) && !$past(set_we_o)) |-> $stable(clk_view));

  // R8: STOP lifts the freeze and releases the line
  a_r8_stop_ends: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (!freeze && !sda_pull_o));
endmodule

bind rtc_i2c_slave rtc_i2c_slave_chk #(.AW(AW), .NCLK(NCLK), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_pull_o(sda_pull_o), .state(state), .ptr(ptr),
  .freeze(freeze), .set_we_o(set_we_o), .clk_view(clk_view)
);

// File: tb/test_rtc_i2c_slave.sv
`timescale 1ns/1ps
module test_rtc_i2c_slave;
  localparam int NCLK = 7;
  localparam int AW   = 3;
  localparam int Q    = 10;

  typedef struct {
    logic [7:0] addr;
    logic [7:0] data;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic sda_bus;
  logic [NCLK*8-1:0] live;
  logic sda_pull, set_we;
  logic [AW-1:0] set_addr;
  logic [7:0] set_data;

  int errs = 0, checks = 0, unstable = 0;
  bit done = 0;
  exp_t rd_exp_q[$];
  logic [7:0] rd_got_q[$];
  exp_t wr_exp_q[$];
  logic [NCLK*8-1:0] t1, t2, t3, t4;

  always #4 clk = ~clk;
  assign sda_bus = msda & ~sda_pull;

  rtc_i2c_slave i_rtc_i2c_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .live_time_i(live),
    .set_we_o(set_we), .set_addr_o(set_addr), .set_data_o(set_data)
  );

  function automatic logic [NCLK*8-1:0] mk(input logic [7:0] s);
    logic [NCLK*8-1:0] v;
    for (int k = 0; k < NCLK; k++) v[k*8 +: 8] = s + 8'(k * 37);
    return v;
  endfunction

  function automatic logic [7:0] tb(input logic [NCLK*8-1:0] t, input int k);
    return t[k*8 +: 8];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  // monitor: compares design results against the scoreboard queues
  always @(negedge clk) begin
    if (rd_got_q.size() > 0) begin
      logic [7:0] g;
      g = rd_got_q.pop_front();
      if (rd_exp_q.size() == 0) chk(0, "read with no expectation", g, 0);
      else begin
        exp_t e;
        e = rd_exp_q.pop_front();
        chk(g == e.data, e.tag, g, e.data);
      end
    end
    if (!rst && set_we) begin
      if (wr_exp_q.size() == 0) chk(0, "R1 R2 unexpected write strobe", set_data, 0);
      else begin
        exp_t e;
        e = wr_exp_q.pop_front();
        chk({5'd0, set_addr} == e.addr && set_data == e.data, e.tag,
            {set_addr, set_data}, {e.addr[2:0], e.data});
      end
    end
  end

  task automatic bstart();
    msda = 1'b1; qw(); scl = 1'b1; qw(); msda = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bstop();
    msda = 1'b0; qw(); scl = 1'b1; qw(); msda = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    msda = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
  endtask

  task automatic recv_bit(output logic b);
    logic b0;
    msda = 1'b1; qw(); scl = 1'b1;
    @(negedge clk); b0 = sda_bus;
    repeat (Q - 1) @(negedge clk);
    b = sda_bus;
    qw();
    if (b0 != sda_bus) unstable++;
    scl = 1'b0; qw();
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    ack = !a;
  endtask

  task automatic rd_byte(input bit ack, input logic [7:0] expv, input string tag);
    logic [7:0] v;
    logic b;
    exp_t e;
    e.addr = '0; e.data = expv; e.tag = tag;
    rd_exp_q.push_back(e);
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(!ack);
    rd_got_q.push_back(v);
  endtask

  task automatic exp_wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    e.addr = a; e.data = d; e.tag = tag;
    wr_exp_q.push_back(e);
  endtask

  task automatic put(input logic [7:0] v, input bit want, input string tag);
    bit a;
    wr_byte(v, a);
    chk(a == want, tag, a, want);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    t1 = mk(8'h10); t2 = mk(8'h51); t3 = mk(8'h92); t4 = mk(8'hC3);
    live = t1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(sda_pull == 1'b0, "R11 line released after reset", sda_pull, 0);

    // R11 / R4: current-address read right after reset returns register 0
    bstart(); put(8'hD1, 1, "R1 address ack");
    rd_byte(0, tb(t1, 0), "R11 R4 pointer 0 after reset"); bstop();

    // R1: foreign address is not acknowledged, nothing written
    bstart(); put(8'hA0, 0, "R1 foreign address no ack");
    put(8'h07, 0, "R1 data after foreign address no ack"); bstop();

    // R2: pointer load then two writes, wrapping 7 -> 0
    bstart(); put(8'hD0, 1, "R2 address ack");
    put(8'h07, 1, "R2 pointer byte ack");
    exp_wr(8'd7, 8'hA5, "R2 write strobe reg7");
    put(8'hA5, 1, "R2 data ack");
    exp_wr(8'd0, 8'h3C, "R2 write strobe wrap to reg0");
    put(8'h3C, 1, "R2 data ack after wrap"); bstop();

    // R2 / R3 / R5: random read of reg7 then acknowledged step to reg0
    bstart(); put(8'hD0, 1, "R3 address ack");
    put(8'h07, 1, "R3 pointer ack");
    bstart(); put(8'hD1, 1, "R3 read address ack");
    rd_byte(1, 8'hA5, "R2 R3 control register readback");
    rd_byte(0, tb(t1, 0), "R5 acknowledged step to reg0"); bstop();

    // R7 / R9 / R6: burst read with live time changing mid-burst
    bstart(); put(8'hD0, 1, "R7 address ack");
    put(8'h00, 1, "R7 pointer ack");
    bstart(); put(8'hD1, 1, "R7 read address ack");
    rd_byte(1, tb(t1, 0), "R7 byte0");
    live = t2;
    for (int k = 1; k < NCLK; k++) rd_byte(1, tb(t1, k), "R7 frozen burst byte");
    rd_byte(1, 8'hA5, "R9 reg7 in burst");
    rd_byte(0, tb(t2, 0), "R9 refresh resumed at pointer 7");
    rd_byte(0, 8'hFF, "R6 line released after NACK"); bstop();

    // R8 / R4 / R5: after STOP the copy follows live; NACK kept pointer at 0
    live = t3;
    qw();
    bstart(); put(8'hD1, 1, "R8 address ack");
    rd_byte(0, tb(t3, 0), "R8 R4 R5 refreshed after STOP"); bstop();

    // R10: freeze holds across write plus repeated START
    bstart(); put(8'hD0, 1, "R10 address ack");
    put(8'h02, 1, "R10 pointer ack");
    live = t4;
    exp_wr(8'd2, 8'h55, "R10 write strobe reg2");
    put(8'h55, 1, "R10 data ack");
    bstart(); put(8'hD1, 1, "R10 read address ack");
    rd_byte(1, tb(t3, 3), "R10 frozen byte3");
    rd_byte(0, tb(t3, 4), "R10 frozen byte4"); bstop();
    qw();
    bstart(); put(8'hD1, 1, "R8 address ack");
    rd_byte(0, tb(t4, 4), "R8 R5 current read after STOP"); bstop();

    // R12: START in the middle of an address byte
    bstart();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bstart(); put(8'hD1, 1, "R12 address after aborted byte");
    rd_byte(0, tb(t4, 4), "R12 read after restart"); bstop();

    repeat (20) @(negedge clk);
    chk(unstable == 0, "R3 SDA steady while SCL high", unstable, 0);
    chk(wr_exp_q.size() == 0, "R2 all write strobes seen", wr_exp_q.size(), 0);
    chk(rd_exp_q.size() == 0, "R3 all reads compared", rd_exp_q.size(), 0);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule